// File: doc/BRIEF.md
# Dual-width host parallel bus bridge

This block sits between a host microprocessor and a character display controller core. The host reaches it over three strobes: a register-select line, a read/write line and an enable line. It also uses an eight-line bidirectional data bus. The bridge turns each completed host transfer into one single-cycle strobe toward the core:

- a command write;
- a data write;
- a data read.

A write strobe comes with the assembled byte. A status read needs no strobe. The bridge returns the core's busy flag and address counter on status reads, and the core's read byte on data reads. It also gives a tristate enable for the bus drivers.

The bus width can change while the block is running. After reset the bridge moves whole bytes. A command write whose top three bits are `001` is the width-setting command, and the bridge watches for it; bit 4 of that byte selects the width. When the bridge is in the narrow mode, every byte crosses the upper four lines as two nibbles, high nibble first.

The narrow mode is normally entered as follows. While still wide, the host presents only the upper nibble `0010`. The bridge takes this as a full-width write and leaves wide mode. The host then repeats the command as two nibbles.

The enable line is asynchronous to the block clock. It passes through a two-flop synchroniser, and its falling edge is found synchronously. The other bus lines are sampled on that falling edge.

Top module: `mpu_bus_bridge`

## Requirements
- R1: After reset the bridge is in 8-bit mode with the nibble phase cleared, no strobe is active and the bus output enable is low.
- R2: In 8-bit mode, a write with register select 0 (read/write line 0) produces exactly one `cmd_wr_o` pulse, with `byte_o` equal to the eight bus lines sampled at the enable fall.
- R3: A write with register select 1 produces exactly one `dat_wr_o` pulse carrying the written byte, and no command pulse.
- R4: A read with register select 0 drives the busy flag on bit 7 and the 7-bit address counter on bits 6..0, and produces no strobe.
- R5: A read with register select 1 drives `rd_data_i` on the bus and produces one `dat_rd_o` pulse after the transfer completes.
- R6: `bus_oe_o` is high only while the synchronised enable is high and the read/write line is 1.
- R7: A command write whose byte has bits 7..5 equal to `001` sets the mode from bit 4: 1 selects 8-bit, 0 selects 4-bit. The nibble phase is cleared by such a write.
- R8: In 4-bit mode, a write takes two enable pulses. The high nibble is on lines 7..4 first and the low nibble second, and lines 3..0 are ignored. Exactly one strobe follows the second pulse and none follows the first.
- R9: In 4-bit mode, a read returns the high nibble of the read word on lines 7..4 during the first pulse and the low nibble during the second. Lines 3..0 are driven 0.
- R10: A write that arrives while `busy_i` is 1 is still forwarded as a normal strobe.
- R11: The three strobes are each one clock wide, and at most one of them is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Register select: 0 command/status, 1 data |
| bus_rd_i | input | 1 | Direction: 0 write, 1 read |
| bus_en_i | input | 1 | Transfer enable strobe, asynchronous |
| bus_d_i | input | 8 | Data lines as seen from the pads |
| bus_d_o | output | 8 | Data lines driven toward the host |
| bus_oe_o | output | 1 | Tristate enable for `bus_d_o` |
| busy_i | input | 1 | Core busy flag |
| addr_ctr_i | input | 7 | Core address counter |
| rd_data_i | input | 8 | Byte the core offers for a data read |
| cmd_wr_o | output | 1 | One-cycle command write strobe |
| dat_wr_o | output | 1 | One-cycle data write strobe |
| dat_rd_o | output | 1 | One-cycle data read strobe |
| byte_o | output | 8 | Assembled byte for the write strobes |

## Verification
The assertions assume a host that holds the enable line high and then low for several clocks each. Under that assumption, the falling edges seen through the synchroniser are at least two cycles apart, which is why a strobe can never repeat in consecutive cycles. The assertions also assume that select, direction and data stay stable around each enable edge.

The bench keeps every enable phase six clocks long. It changes the other lines only while enable has been low for several cycles. Throughout 4-bit mode it fills the unused lower lines with deliberately wrong values.

// File: rtl/mpub_pkg.sv
package mpub_pkg;

    typedef enum logic [1:0] {
        XK_CMD_WR  = 2'd0,
        XK_STAT_RD = 2'd1,
        XK_DAT_WR  = 2'd2,
        XK_DAT_RD  = 2'd3
    } xfer_kind_e;

    // Register select and direction together name the transaction.
    function automatic xfer_kind_e decode_kind(input logic sel, input logic rd);
        case ({sel, rd})
            2'b00:   return XK_CMD_WR;
            2'b01:   return XK_STAT_RD;
            2'b10:   return XK_DAT_WR;
            default: return XK_DAT_RD;
        endcase
    endfunction

endpackage

// File: rtl/mpub_sync.sv
module mpub_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/mpub_rdmux.sv
module mpub_rdmux #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic              wide_i,
    input  logic              second_i,
    output logic [DATA_W-1:0] bus_o
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        if (wide_i) begin
            bus_o = word_i;
        end else if (second_i) begin
            bus_o = {word_i[HALF_W-1:0], {HALF_W{1'b0}}};
        end else begin
            bus_o = {word_i[DATA_W-1:HALF_W], {HALF_W{1'b0}}};
        end
    end

endmodule

// File: rtl/mpu_bus_bridge.sv
module mpu_bus_bridge
    import mpub_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_rd_i,
    input  logic              bus_en_i,
    input  logic [DATA_W-1:0] bus_d_i,
    output logic [DATA_W-1:0] bus_d_o,
    output logic              bus_oe_o,
    input  logic              busy_i,
    input  logic [DATA_W-2:0] addr_ctr_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              cmd_wr_o,
    output logic              dat_wr_o,
    output logic              dat_rd_o,
    output logic [DATA_W-1:0] byte_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int DL_BIT = DATA_W - 4;
    localparam logic [2:0] WIDTH_CMD_TAG = 3'b001;

    typedef struct packed {
        logic              wide;
        logic              second;
        logic [HALF_W-1:0] hi_nib;
        logic [DATA_W-1:0] word;
        logic [DATA_W-1:0] wbyte;
        logic              cmd_stb;
        logic              dw_stb;
        logic              dr_stb;
    } state_t;

    state_t st_d, st_q;

    logic en_lvl, en_rise, en_fall;
    logic mode8_w;

    mpub_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (bus_en_i),
        .level_o (en_lvl),
        .rise_o  (en_rise),
        .fall_o  (en_fall)
    );

    always_comb begin
        logic [DATA_W-1:0] full;
        xfer_kind_e        kind;

        st_d         = st_q;
        st_d.cmd_stb = 1'b0;
        st_d.dw_stb  = 1'b0;
        st_d.dr_stb  = 1'b0;
        kind         = decode_kind(bus_sel_i, bus_rd_i);
        full         = st_q.wide ? bus_d_i : {st_q.hi_nib, bus_d_i[DATA_W-1:HALF_W]};

        // The read word is captured once per byte, at the first enable rise.
        if (en_rise && (st_q.wide || !st_q.second)) begin
            st_d.word = bus_sel_i ? rd_data_i : {busy_i, addr_ctr_i};
        end

        if (en_fall) begin
            if (!st_q.wide && !st_q.second) begin
                st_d.second = 1'b1;
                if (!bus_rd_i) begin
                    st_d.hi_nib = bus_d_i[DATA_W-1:HALF_W];
                end
            end else begin
                st_d.second = 1'b0;
                case (kind)
                    XK_CMD_WR: begin
                        st_d.wbyte   = full;
                        st_d.cmd_stb = 1'b1;
                        if (full[DATA_W-1:DATA_W-3] == WIDTH_CMD_TAG) begin
                            st_d.wide = full[DL_BIT];
                        end
                    end
                    XK_DAT_WR: begin
                        st_d.wbyte  = full;
                        st_d.dw_stb = 1'b1;
                    end
                    XK_DAT_RD: st_d.dr_stb = 1'b1;
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.wide   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    mpub_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .word_i   (st_q.word),
        .wide_i   (st_q.wide),
        .second_i (st_q.second),
        .bus_o    (bus_d_o)
    );

    assign mode8_w  = st_q.wide;
    assign bus_oe_o = en_lvl & bus_rd_i;
    assign cmd_wr_o = st_q.cmd_stb;
    assign dat_wr_o = st_q.dw_stb;
    assign dat_rd_o = st_q.dr_stb;
    assign byte_o   = st_q.wbyte;

endmodule

// File: rtl/mpub_checker.sv
module mpub_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd_i,
    input logic              bus_oe_o,
    input logic [DATA_W-1:0] bus_d_o,
    input logic              cmd_wr_o,
    input logic              dat_wr_o,
    input logic              dat_rd_o,
    input logic              mode8
);
    localparam int HALF_W = DATA_W / 2;

    // R6: drive only on reads
    a_r6_oe_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> bus_rd_i);

    // R11: at most one strobe per cycle
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_wr_o, dat_wr_o, dat_rd_o}));

    // R11: each strobe lasts one cycle
    a_r11_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr_o |=> !cmd_wr_o);

    a_r11_dw_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr_o |=> !dat_wr_o);

    a_r11_dr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dat_rd_o |=> !dat_rd_o);

    // R9: unused lower lines stay low in nibble mode
    a_r9_low_lines_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && !mode8) |-> (bus_d_o[HALF_W-1:0] == '0));

endmodule

bind mpu_bus_bridge mpub_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd_i (bus_rd_i),
    .bus_oe_o (bus_oe_o),
    .bus_d_o  (bus_d_o),
    .cmd_wr_o (cmd_wr_o),
    .dat_wr_o (dat_wr_o),
    .dat_rd_o (dat_rd_o),
    .mode8    (mode8_w)
);

// File: tb/mpu_bus_bridge_test.sv
module mpu_bus_bridge_test;
    localparam int CLK_P = 10;
    localparam int HOLD  = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, rd = 1'b0, en = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       oe;
    logic       busy = 1'b0;
    logic [6:0] ac = 7'h00;
    logic [7:0] rdat = 8'h00;
    logic       cmd_wr, dat_wr, dat_rd;
    logic [7:0] wbyte;

    int checks = 0, errors = 0;
    int n_cmd = 0, n_dw = 0, n_dr = 0;
    logic [7:0] last_byte = 8'h00;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mpu_bus_bridge uut (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_rd_i(rd), .bus_en_i(en),
        .bus_d_i(din), .bus_d_o(dout), .bus_oe_o(oe), .busy_i(busy),
        .addr_ctr_i(ac), .rd_data_i(rdat), .cmd_wr_o(cmd_wr), .dat_wr_o(dat_wr),
        .dat_rd_o(dat_rd), .byte_o(wbyte)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_wr) begin n_cmd++; last_byte = wbyte; end
            if (dat_wr) begin n_dw++;  last_byte = wbyte; end
            if (dat_rd) n_dr++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One enable pulse; returns what the bridge drove while enable was high.
    task automatic xfer(input logic s, input logic r, input logic [7:0] d,
                        output logic [7:0] seen, output logic seen_oe);
        @(negedge clk);
        sel = s; rd = r; din = d;
        repeat (2) @(negedge clk);
        en = 1'b1;
        repeat (HOLD) @(negedge clk);
        seen = dout; seen_oe = oe;
        en = 1'b0;
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic wr8(input logic s, input logic [7:0] b);
        logic [7:0] x; logic o;
        xfer(s, 1'b0, b, x, o);
    endtask

    task automatic wr4(input logic s, input logic [7:0] b);
        logic [7:0] x; logic o;
        xfer(s, 1'b0, {b[7:4], ~b[3:0]}, x, o);
        xfer(s, 1'b0, {b[3:0], b[7:4]}, x, o);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] s1, s2;
        logic o1, o2;
        int c0, d0, r0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd = 1'b1;
        repeat (4) @(negedge clk);
        // R1 / R6: enable low gives no drive and no strobe
        chk(oe == 1'b0, "R1 oe after reset", oe, 0);
        chk({cmd_wr, dat_wr, dat_rd} == 3'b000, "R1 strobes idle", {cmd_wr, dat_wr, dat_rd}, 0);

        // R6: write pulse never drives the bus
        xfer(1'b1, 1'b0, 8'h11, s1, o1);
        chk(o1 == 1'b0, "R6 no drive on write", o1, 0);
        chk(n_dw == 1, "R1 starts in 8-bit mode", n_dw, 1);

        // R3: full sweep of data writes in 8-bit mode, busy toggled for R10
        for (int b = 0; b < 256; b++) begin
            d0 = n_dw; c0 = n_cmd;
            busy = b[0];
            wr8(1'b1, b[7:0]);
            chk(n_dw == d0 + 1 && n_cmd == c0 && last_byte == b[7:0],
                busy ? "R10 data write while busy" : "R3 data write 8-bit",
                last_byte, b);
        end
        busy = 1'b0;

        // R2: command writes, skipping the width-setting group with bit 4 low
        for (int b = 0; b < 256; b++) begin
            if (b[7:4] == 4'h2) continue;
            c0 = n_cmd;
            wr8(1'b0, b[7:0]);
            chk(n_cmd == c0 + 1 && last_byte == b[7:0], "R2 command write 8-bit", last_byte, b);
        end

        // R4: status reads over every address counter value
        for (int a = 0; a < 128; a++) begin
            ac = a[6:0]; busy = a[2];
            c0 = n_cmd; d0 = n_dw; r0 = n_dr;
            xfer(1'b0, 1'b1, 8'h00, s1, o1);
            chk(o1 && s1 == {a[2], a[6:0]}, "R4 status read", s1, {a[2], a[6:0]});
            chk(n_cmd == c0 && n_dw == d0 && n_dr == r0, "R4 no strobe on status", n_dr, r0);
        end
        busy = 1'b0;

        // R5: data reads
        for (int v = 0; v < 256; v += 17) begin
            rdat = v[7:0]; r0 = n_dr;
            xfer(1'b1, 1'b1, 8'h00, s1, o1);
            chk(o1 && s1 == v[7:0], "R5 data read value", s1, v);
            chk(n_dr == r0 + 1, "R5 one read strobe", n_dr, r0 + 1);
        end

        // R7: width command 0x2_ sent wide with junk low lines selects 4-bit
        c0 = n_cmd;
        wr8(1'b0, 8'h25);
        chk(n_cmd == c0 + 1 && last_byte == 8'h25, "R7 width command accepted", last_byte, 8'h25);

        // R8: first nibble alone gives no strobe
        c0 = n_cmd;
        xfer(1'b0, 1'b0, 8'h2F, s1, o1);
        chk(n_cmd == c0, "R8 no strobe after first nibble", n_cmd, c0);
        xfer(1'b0, 1'b0, 8'h83, s1, o1);
        chk(n_cmd == c0 + 1 && last_byte == 8'h28, "R8 two-nibble command", last_byte, 8'h28);

        // R8 / R10: full sweep of 4-bit data writes, junk on lines 3..0
        for (int b = 0; b < 256; b++) begin
            d0 = n_dw;
            busy = b[1];
            wr4(1'b1, b[7:0]);
            chk(n_dw == d0 + 1 && last_byte == b[7:0],
                busy ? "R10 nibble write while busy" : "R8 nibble data write", last_byte, b);
        end
        busy = 1'b0;

        // R9: nibble status and data reads
        for (int a = 0; a < 128; a += 9) begin
            ac = a[6:0]; busy = a[0];
            xfer(1'b0, 1'b1, 8'h00, s1, o1);
            xfer(1'b0, 1'b1, 8'h00, s2, o2);
            chk(o1 && s1 == {a[0], a[6:4], 4'h0}, "R9 status high nibble", s1, {a[0], a[6:4], 4'h0});
            chk(o2 && s2 == {a[3:0], 4'h0}, "R9 status low nibble", s2, {a[3:0], 4'h0});
        end
        busy = 1'b0;
        for (int v = 3; v < 256; v += 29) begin
            rdat = v[7:0]; r0 = n_dr;
            xfer(1'b1, 1'b1, 8'h00, s1, o1);
            chk(n_dr == r0, "R9 no read strobe after first nibble", n_dr, r0);
            xfer(1'b1, 1'b1, 8'h00, s2, o2);
            chk(s1 == {v[7:4], 4'h0} && s2 == {v[3:0], 4'h0}, "R9 data read nibbles",
                {s1, s2}, {v[7:4], 4'h0, v[3:0], 4'h0});
            chk(n_dr == r0 + 1, "R5 read strobe in nibble mode", n_dr, r0 + 1);
        end

        // R7: width command with bit 4 set returns to 8-bit
        c0 = n_cmd;
        wr4(1'b0, 8'h38);
        chk(n_cmd == c0 + 1 && last_byte == 8'h38, "R7 back to 8-bit command", last_byte, 8'h38);
        d0 = n_dw;
        wr8(1'b1, 8'hA5);
        chk(n_dw == d0 + 1 && last_byte == 8'hA5, "R7 single-pulse write after return", last_byte, 8'hA5);

        // R1: reset mid nibble restores 8-bit mode
        wr8(1'b0, 8'h20);
        xfer(1'b1, 1'b0, 8'hC0, s1, o1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        d0 = n_dw;
        wr8(1'b1, 8'h5A);
        chk(n_dw == d0 + 1 && last_byte == 8'h5A, "R1 reset clears phase and mode", last_byte, 8'h5A);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule